// File: doc/BRIEF.md
# DSP Bus Glue Registers with Boot-Strap Interrupt Gating

This block is a small memory-mapped peripheral on a DSP external bus. It splits the top of the word address space into pages and decodes two of them into write registers. The control register drives the codec's active-low reset and an interrupt gate. The gate decides whether the processor's interrupt pins carry the strap (jumper) levels or the live external interrupt requests. Strap levels are present at reset so the processor can sample its boot mode. Software opens the gate after boot.

The codec register drives three software-toggled control lines (data, clock and sync) for a bit-banged serial link to a codec. Reading that page returns the codec's serial status input on bit 0. The status path passes through a synchronizer of `SYNC_STAGES` flops. With `SYNC_STAGES = 0` it is a direct, unlatched path. Software does all serial framing.

The interrupt gate is a two-state machine. `GATE_STRAP` is the state after reset; in it the pins follow the straps. `GATE_LIVE` means the pins follow the requests. A control-page write with bit 1 = 1 moves the machine to `GATE_LIVE`, and a control-page write with bit 1 = 0 moves it to `GATE_STRAP`. Reset always returns it to `GATE_STRAP`. The page decoder classifies the two top address bits as `PG_MEM0` (00), `PG_MEM1` (01), `PG_CTRL` (10) and `PG_CODEC` (11).

Top module: `dsp_glue_regs`

## Requirements
- R1: After reset, `codec_rst_n` is 0, `cdc_dout`, `cdc_clk` and `cdc_sync` are 0, and `int_pin` equals `strap_lvl`.
- R2: A write with `addr[23:22] = 2'b10`, `xstrb_n` = 0 and `int_acc` = 0 updates the control register on the next rising clock edge, whatever the lower 22 address bits are.
- R3: A write with `addr[23:22] = 2'b11`, `xstrb_n` = 0 and `int_acc` = 0 updates the codec register on the next rising clock edge, whatever the lower 22 address bits are.
- R4: No register is selected, and writes have no effect, when `int_acc` = 1, when `xstrb_n` = 1, or when `addr[23]` = 0.
- R5: Control-register bit 0 drives `codec_rst_n`.
- R6: While control-register bit 1 is 0, `int_pin` equals `strap_lvl`. While it is 1, `int_pin` equals `irq_req`. This includes interrupt 0, which serves the codec.
- R7: `rdata` is all zeros except during a read (`rd_en` = 1) of the codec page. A read of the control page returns zeros.
- R8: Codec-register bit 0 drives `cdc_dout`, bit 1 drives `cdc_clk` and bit 2 drives `cdc_sync`.
- R9: A read of the codec page returns the codec status input on `rdata[0]`. The value is delayed by `SYNC_STAGES` rising edges, or passed straight through when `SYNC_STAGES` = 0.
- R10: Write-data bits above the defined fields are ignored, and they read back as 0.
- R11: When a read and a write of the codec page fall in the same cycle, `rdata` shows the status bit and not the write data, and the write still takes effect at the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | Word address |
| xstrb_n | input | 1 | External access strobe, active low |
| int_acc | input | 1 | Processor internal access flag |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (zero when not driven) |
| strap_lvl | input | 4 | Boot-mode strap levels |
| irq_req | input | 4 | Live external interrupt requests |
| int_pin | output | 4 | Processor interrupt pins |
| codec_rst_n | output | 1 | Codec reset, active low |
| cdc_dout | output | 1 | Codec control serial data |
| cdc_clk | output | 1 | Codec control serial clock |
| cdc_sync | output | 1 | Codec control frame sync |
| cdc_din | input | 1 | Codec status serial data |

## Verification
A read of the status path and a write of the codec register can fall in the same bus cycle on the codec page. The bench provokes this by raising `rd_en` and `wr_en` together with write data that differs from the status bit. It then judges `rdata` before the edge against the status value, and the control outputs after the edge against the written bits. A second case changes the gate state while the strap and request vectors differ in every bit, so each pin shows which source it carries.

// File: rtl/glue_pkg.sv
package glue_pkg;

    typedef enum logic [1:0] {
        PG_MEM0  = 2'b00,
        PG_MEM1  = 2'b01,
        PG_CTRL  = 2'b10,
        PG_CODEC = 2'b11
    } page_e;

    typedef enum logic {
        GATE_STRAP = 1'b0,
        GATE_LIVE  = 1'b1
    } gate_e;

    localparam int CTRL_RST_BIT  = 0;
    localparam int CTRL_GATE_BIT = 1;
    localparam int CDC_DOUT_BIT  = 0;
    localparam int CDC_CLK_BIT   = 1;
    localparam int CDC_SYNC_BIT  = 2;

endpackage

// File: rtl/glue_page_decode.sv
module glue_page_decode
    import glue_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              xstrb_n,
    input  logic              int_acc,
    output logic              sel_ctrl,
    output logic              sel_codec
);
    localparam int PAGE_LSB = ADDR_W - 2;

    page_e page;
    logic  ext_cycle;
    logic  unused_low;

    assign page       = page_e'(addr[ADDR_W-1:PAGE_LSB]);
    assign ext_cycle  = !xstrb_n && !int_acc;
    assign unused_low = ^addr[PAGE_LSB-1:0];

    always_comb begin
        sel_ctrl  = 1'b0;
        sel_codec = 1'b0;
        unique case (page)
            PG_CTRL:  sel_ctrl  = ext_cycle;
            PG_CODEC: sel_codec = ext_cycle;
            PG_MEM0,
            PG_MEM1:  ;
            default:  ;
        endcase
    end

    // R4: no register select during an internal access
    a_r4_no_sel_internal: assert property (@(posedge clk) disable iff (!rst_n)
        int_acc |-> !(sel_ctrl || sel_codec));

    // R4: strobe inactive keeps both selects low
    a_r4_no_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        xstrb_n |-> !(sel_ctrl || sel_codec));

    // R2, R3: at most one page selected
    a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ctrl, sel_codec}));

endmodule

// File: rtl/glue_ctrl_reg.sv
module glue_ctrl_reg
    import glue_pkg::*;
#(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [1:0]         wbits,
    input  logic [NUM_IRQ-1:0] strap_lvl,
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic [NUM_IRQ-1:0] int_pin,
    output logic               codec_rst_n
);
    gate_e gate_q, gate_d;

    // next-state process
    always_comb begin
        gate_d = gate_q;
        unique case (gate_q)
            GATE_STRAP: if (wr_hit && wbits[CTRL_GATE_BIT])  gate_d = GATE_LIVE;
            GATE_LIVE:  if (wr_hit && !wbits[CTRL_GATE_BIT]) gate_d = GATE_STRAP;
            default:    gate_d = GATE_STRAP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= GATE_STRAP;
        else        gate_q <= gate_d;
    end

    // codec reset bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      codec_rst_n <= 1'b0;
        else if (wr_hit) codec_rst_n <= wbits[CTRL_RST_BIT];
    end

    // output process
    always_comb begin
        unique case (gate_q)
            GATE_STRAP: int_pin = strap_lvl;
            GATE_LIVE:  int_pin = irq_req;
            default:    int_pin = strap_lvl;
        endcase
    end

    // R5: reset line follows the written bit
    a_r5_rst_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> codec_rst_n == $past(wbits[CTRL_RST_BIT]));

    // R6: gate state changes only on a control write
    a_r6_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(gate_q));

    // R6: a control write sets the gate to the written bit
    a_r6_gate_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (gate_q == GATE_LIVE) == $past(wbits[CTRL_GATE_BIT]));

endmodule

// File: rtl/glue_codec_port.sv
module glue_codec_port
    import glue_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [2:0] wbits,
    input  logic       cdc_din,
    output logic       cdc_dout,
    output logic       cdc_clk,
    output logic       cdc_sync,
    output logic       status_bit
);
    logic [2:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_hit) ctl_q <= wbits;
    end

    assign cdc_dout = ctl_q[CDC_DOUT_BIT];
    assign cdc_clk  = ctl_q[CDC_CLK_BIT];
    assign cdc_sync = ctl_q[CDC_SYNC_BIT];

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign status_bit = cdc_din;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], cdc_din};
            end
            assign status_bit = sync_q[SYNC_STAGES-1];

            // R9: first stage captures the pin
            a_r9_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> sync_q[0] == $past(cdc_din));
        end
    endgenerate

    // R8: outputs take the written bits
    a_r8_ctl_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> {cdc_sync, cdc_clk, cdc_dout} == $past(wbits));

    // R8: outputs hold without a write
    a_r8_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable({cdc_sync, cdc_clk, cdc_dout}));

endmodule

// File: rtl/dsp_glue_regs.sv
module dsp_glue_regs
    import glue_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 32,
    parameter int NUM_IRQ     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               xstrb_n,
    input  logic               int_acc,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_IRQ-1:0] strap_lvl,
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic [NUM_IRQ-1:0] int_pin,
    output logic               codec_rst_n,
    output logic               cdc_dout,
    output logic               cdc_clk,
    output logic               cdc_sync,
    input  logic               cdc_din
);
    localparam int CTRL_W  = 2;
    localparam int CODEC_W = 3;

    logic sel_ctrl, sel_codec;
    logic status_bit;
    logic unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:CODEC_W];

    glue_page_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .xstrb_n   (xstrb_n),
        .int_acc   (int_acc),
        .sel_ctrl  (sel_ctrl),
        .sel_codec (sel_codec)
    );

    glue_ctrl_reg #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (sel_ctrl && wr_en),
        .wbits       (wdata[CTRL_W-1:0]),
        .strap_lvl   (strap_lvl),
        .irq_req     (irq_req),
        .int_pin     (int_pin),
        .codec_rst_n (codec_rst_n)
    );

    glue_codec_port #(.SYNC_STAGES(SYNC_STAGES)) u_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_hit     (sel_codec && wr_en),
        .wbits      (wdata[CODEC_W-1:0]),
        .cdc_din    (cdc_din),
        .cdc_dout   (cdc_dout),
        .cdc_clk    (cdc_clk),
        .cdc_sync   (cdc_sync),
        .status_bit (status_bit)
    );

    always_comb begin
        rdata = '0;
        if (sel_codec && rd_en) rdata[0] = status_bit;
    end

    // R7: bus stays zero with no read strobe
    a_r7_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);

    // R10: only bit 0 can ever be driven
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:1] == '0);

endmodule

// File: tb/dsp_glue_regs_tb.sv
`timescale 1ns/1ps
module dsp_glue_regs_tb;

    localparam int CLK_HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] addr = '0;
    logic        xstrb_n = 1'b1;
    logic        int_acc = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_raw;
    logic [3:0]  strap_lvl = 4'b1010;
    logic [3:0]  irq_req = 4'b0101;
    logic [3:0]  int_pin, int_pin_raw;
    logic        codec_rst_n, cdc_dout, cdc_clk, cdc_sync, cdc_din = 1'b0;
    logic        rst_raw, dout_raw, clk_raw, sync_raw;

    int checks = 0;
    int errors = 0;

    always #CLK_HALF clk = ~clk;

    dsp_glue_regs u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .xstrb_n(xstrb_n), .int_acc(int_acc),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .strap_lvl(strap_lvl), .irq_req(irq_req), .int_pin(int_pin),
        .codec_rst_n(codec_rst_n), .cdc_dout(cdc_dout), .cdc_clk(cdc_clk),
        .cdc_sync(cdc_sync), .cdc_din(cdc_din)
    );

    dsp_glue_regs #(.SYNC_STAGES(0)) u_dut_raw (
        .clk(clk), .rst_n(rst_n), .addr(addr), .xstrb_n(xstrb_n), .int_acc(int_acc),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata_raw),
        .strap_lvl(strap_lvl), .irq_req(irq_req), .int_pin(int_pin_raw),
        .codec_rst_n(rst_raw), .cdc_dout(dout_raw), .cdc_clk(clk_raw),
        .cdc_sync(sync_raw), .cdc_din(cdc_din)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [23:0] a, input logic [31:0] d,
                             input logic strb_n, input logic internal);
        @(negedge clk);
        addr = a; wdata = d; xstrb_n = strb_n; int_acc = internal; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; xstrb_n = 1'b1; int_acc = 1'b0;
        #2;
    endtask

    task automatic bus_read(input logic [23:0] a, input logic strb_n, output logic [31:0] d);
        @(negedge clk);
        addr = a; xstrb_n = strb_n; rd_en = 1'b1;
        #2;
        d = rdata;
        @(negedge clk);
        rd_en = 1'b0; xstrb_n = 1'b1;
    endtask

    function automatic logic [31:0] ctl3();
        return {29'd0, cdc_sync, cdc_clk, cdc_dout};
    endfunction

    task automatic t_reset();
        chk("R1 codec reset low", {31'd0, codec_rst_n}, 32'd0);
        chk("R1 control lines low", ctl3(), 32'd0);
        chk("R1 pins carry straps", {28'd0, int_pin}, {28'd0, strap_lvl});
    endtask

    task automatic t_ctrl_alias();
        bus_write(24'h800000, 32'h3, 1'b0, 1'b0);
        chk("R5 codec reset released", {31'd0, codec_rst_n}, 32'd1);
        chk("R6 pins carry requests", {28'd0, int_pin}, {28'd0, irq_req});
        irq_req = 4'b0001;
        #1;
        chk("R6 interrupt 0 passes", {28'd0, int_pin}, 32'h1);
        irq_req = 4'b0101;
        bus_write(24'hBFFFFF, 32'h0, 1'b0, 1'b0);
        chk("R2 alias top of page", {31'd0, codec_rst_n}, 32'd0);
        chk("R6 straps back", {28'd0, int_pin}, {28'd0, strap_lvl});
        bus_write(24'hA12345, 32'h2, 1'b0, 1'b0);
        chk("R2 alias mid page", {27'd0, codec_rst_n, int_pin}, {27'd0, 1'b0, irq_req});
    endtask

    task automatic t_codec_alias();
        bus_write(24'hC00000, 32'h7, 1'b0, 1'b0);
        chk("R8 all control set", ctl3(), 32'h7);
        bus_write(24'hFFFFFF, 32'h2, 1'b0, 1'b0);
        chk("R3 alias, clock only", ctl3(), 32'h2);
        bus_write(24'hD5A5A5, 32'h5, 1'b0, 1'b0);
        chk("R8 data and sync", ctl3(), 32'h5);
    endtask

    task automatic t_blocked();
        bus_write(24'h800000, 32'h1, 1'b0, 1'b1);
        chk("R4 internal access ignored", {27'd0, codec_rst_n, int_pin}, {27'd0, 1'b0, irq_req});
        bus_write(24'hC00000, 32'h2, 1'b1, 1'b0);
        chk("R4 strobe inactive ignored", ctl3(), 32'h5);
        bus_write(24'h400000, 32'h0, 1'b0, 1'b0);
        bus_write(24'h000000, 32'h1, 1'b0, 1'b0);
        chk("R4 memory pages ignored", {26'd0, ctl3()[2:0], codec_rst_n, 2'd0}, {26'd0, 3'h5, 1'b0, 2'd0});
    endtask

    task automatic t_read_ctrl();
        logic [31:0] d;
        bus_write(24'h800000, 32'h3, 1'b0, 1'b0);
        cdc_din = 1'b1;
        repeat (3) @(negedge clk);
        bus_read(24'h800000, 1'b0, d);
        chk("R7 control page reads zero", d, 32'h0);
        bus_read(24'hC00000, 1'b1, d);
        chk("R7 no strobe reads zero", d, 32'h0);
        #1;
        chk("R7 idle bus zero", rdata, 32'h0);
    endtask

    task automatic t_status();
        @(negedge clk);
        cdc_din = 1'b0;
        addr = 24'hC00001; xstrb_n = 1'b0; rd_en = 1'b1;
        #2;
        chk("R9 unlatched path immediate", rdata_raw, 32'h0);
        chk("R9 synced path lags", rdata, 32'h1);
        @(negedge clk);
        #2;
        chk("R9 one edge still old", rdata, 32'h1);
        @(negedge clk);
        #2;
        chk("R9 after two edges new", rdata, 32'h0);
        cdc_din = 1'b1;
        #1;
        chk("R9 unlatched follows pin", rdata_raw, 32'h1);
        rd_en = 1'b0; xstrb_n = 1'b1;
    endtask

    task automatic t_unused();
        logic [31:0] d;
        bus_write(24'hC00000, 32'hFFFF_FFF8, 1'b0, 1'b0);
        chk("R10 upper write bits ignored", ctl3(), 32'h0);
        bus_write(24'h800000, 32'hFFFF_FFFC, 1'b0, 1'b0);
        chk("R10 control upper bits ignored", {27'd0, codec_rst_n, int_pin}, {27'd0, 1'b0, strap_lvl});
        repeat (3) @(negedge clk);
        bus_read(24'hC00000, 1'b0, d);
        chk("R10 upper read bits zero", d, 32'h1);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        cdc_din = 1'b0;
        repeat (3) @(negedge clk);
        addr = 24'hE00000; xstrb_n = 1'b0; rd_en = 1'b1; wr_en = 1'b1; wdata = 32'h7;
        #2;
        chk("R11 read shows status not data", rdata, 32'h0);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; xstrb_n = 1'b1;
        #2;
        chk("R11 write still lands", ctl3(), 32'h7);
    endtask

    initial begin
        #(2 * CLK_HALF * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        t_ctrl_alias();
        t_codec_alias();
        t_blocked();
        t_read_ctrl();
        t_status();
        t_unused();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule